// File: doc/BRIEF.md
# Interrupt Remapping Command Controller

This block owns the command and status path that switches interrupt remapping on or off and loads the remapping table base. Software writes a 32-bit command word. One field of the word asks for remapping to be on or off. A second field is a one-shot trigger that copies a separately written table-address register into the active table pointer. Table walks, entry caching and interrupt delivery belong to other blocks.

Interrupt requests pass through a small in-flight queue. Each accepted request is tagged with the remapping mode in force when it enters the queue. A requested mode change is held pending until the queue has emptied. While it is pending, new requests are refused. No request is ever processed partly in one mode and partly in the other. The enable-status bit therefore reports a new mode only after the queue has drained.

Top module: `irq_remap_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears the active pointer, the table-address register, both status bits, the protocol-error flag and the queue. After reset `req_ready` is 1.
- R2: Suppose `cmd_wr` is high with bit 24 of `cmd_wdata` set in cycle c. At that edge the value held in the table-address register (as it stood before the edge) goes to `active_ptr`, and `sts_ptr_set` becomes 1. Both are visible in cycle c+1.
- R3: A command write with bit 24 clear leaves `active_ptr` unchanged, even if the table-address register now holds a different value.
- R4: `cmd_rdata` reads 0 at all times, including while a command write is in progress.
- R5: Every command write takes bit 25 as the requested mode (1 = on, 0 = off). With the queue empty, `sts_remap_en` takes the requested value in cycle c+2 after a write in cycle c.
- R6: While the requested mode differs from `sts_remap_en`, `req_ready` is 0. `sts_remap_en` does not change in any cycle that follows one with `inflight` nonzero. It changes one cycle after the first cycle in which the queue is empty with a change pending.
- R7: The queue holds DEPTH (default 4) requests. `req_ready` is 0 when `inflight` equals DEPTH. A request offered while `req_ready` is 0 is not counted.
- R8: `req_tag` shows the mode that an accepted request carries, which is `sts_remap_en` in the accept cycle. A request accepted in the same cycle as a mode-change write carries the old mode. `cpl_tag` shows the tag of the oldest queued request, and completions come out in acceptance order.
- R9: A pointer load while remapping is on and requests are queued updates `active_ptr` only. Queued tags, `sts_remap_en` and `req_ready` are left as they were.
- R10: A command write with bit 25 set while `sts_ptr_set` is 0 sets `proto_err` in the following cycle. The flag is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word; bit 25 mode request, bit 24 pointer-load trigger |
| cmd_rdata | output | 32 | Command word read value, always 0 |
| addr_wr | input | 1 | Table-address register write strobe |
| addr_wdata | input | AW | Table base address to hold |
| req_valid | input | 1 | An interrupt request is offered |
| req_ready | output | 1 | The offered request is accepted this cycle |
| req_tag | output | 1 | Mode tag given to a request accepted this cycle |
| req_done | input | 1 | The oldest queued request has finished |
| cpl_tag | output | 1 | Mode tag of the oldest queued request |
| inflight | output | $clog2(DEPTH+1) | Number of queued requests |
| active_ptr | output | AW | Active remapping table pointer |
| sts_remap_en | output | 1 | Remapping enable status |
| sts_ptr_set | output | 1 | A table pointer has been loaded since reset |
| proto_err | output | 1 | Sticky flag: enable was requested before any pointer load |

## Verification
The checker takes it that `req_done` is raised only when `inflight` is nonzero, and that a downstream consumer completes requests strictly in order. The bench pulses completion only after it has counted queued requests itself. The checker also takes it that `cmd_wdata` is meaningful only in cycles with `cmd_wr` high. The bench holds the data at zero outside write strobes and drives every input on the falling edge, so each strobe covers exactly one rising edge.

// File: rtl/irm_pkg.sv
// Shared constants and the decoded command type for the interrupt remapping
// command controller. Assumes a 32-bit software command word.
package irm_pkg;
    localparam int CMD_W  = 32;
    localparam int EN_BIT = 25;   // mode request field position
    localparam int SP_BIT = 24;   // pointer-load trigger position

    typedef struct packed {
        logic wr;   // a command word was written this cycle
        logic en;   // requested mode carried by that write
        logic sp;   // pointer-load trigger (already qualified by wr)
    } cmd_t;
endpackage

// File: rtl/irm_cmd_regs.sv
// Command word decoder and table-address holding register.
// Assumes cmd_wdata is meaningful only while cmd_wr is high. The command
// fields are write-only, so the read value is always zero.
module irm_cmd_regs #(
    parameter int AW = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [irm_pkg::CMD_W-1:0] cmd_wdata,
    input  logic                      addr_wr,
    input  logic [AW-1:0]             addr_wdata,
    output irm_pkg::cmd_t             cmd,
    output logic [AW-1:0]             addr_q,
    output logic [irm_pkg::CMD_W-1:0] cmd_rdata
);
    import irm_pkg::*;

    logic unused_cmd_bits;

    // Decode the command fields from the written word.
    always_comb begin
        cmd.wr = cmd_wr;
        cmd.en = cmd_wdata[EN_BIT];
        cmd.sp = cmd_wr & cmd_wdata[SP_BIT];
    end

    // Bits outside the two command fields carry no function.
    assign unused_cmd_bits = ^{cmd_wdata[CMD_W-1:EN_BIT+1], cmd_wdata[SP_BIT-1:0]};

    // Write-only fields read back as zero.
    assign cmd_rdata = '0;

    // Hold the table base address until the next address write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_wr)
            addr_q <= addr_wdata;
    end
endmodule

// File: rtl/irm_inflight_q.sv
// In-order queue of mode tags for in-flight interrupt requests.
// Assumes push is asserted only when not full. A pop while empty is ignored.
module irm_inflight_q #(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       push_tag,
    input  logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       head_tag,
    output logic                       full,
    output logic                       empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DEPTH-1:0] tags_q;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_pop   = pop && !empty;
    assign head_tag = tags_q[rd_ptr];

    // One storage slot per queue entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                tags_q[i] <= 1'b0;
            else if (push && wr_ptr == PW'(i))
                tags_q[i] <= push_tag;
        end
    end

    // Advance the pointers with wrap at DEPTH and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            if (push && !do_pop)
                count <= count + CW'(1);
            else if (do_pop && !push)
                count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/irm_mode_ctrl.sv
// Mode sequencer, active table pointer and status flags.
// The requested mode is taken on every command write. The live mode follows
// it only once the request queue is empty. A pointer load completes at the
// write edge.
module irm_mode_ctrl #(
    parameter int AW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  irm_pkg::cmd_t cmd,
    input  logic [AW-1:0] addr_q,
    input  logic          q_empty,
    output logic          mode_q,
    output logic          pending,
    output logic [AW-1:0] ptr_q,
    output logic          ptr_ok_q,
    output logic          err_q
);
    logic target_q;

    assign pending = (target_q != mode_q);

    // Record the mode requested by the latest command write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target_q <= 1'b0;
        else if (cmd.wr)
            target_q <= cmd.en;
    end

    // Switch the live mode only at a request boundary (queue empty).
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (pending && q_empty)
            mode_q <= target_q;
    end

    // Load the active pointer on the one-shot trigger and mark it loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            ptr_ok_q <= 1'b0;
        end else if (cmd.sp) begin
            ptr_q    <= addr_q;
            ptr_ok_q <= 1'b1;
        end
    end

    // Flag an enable request made before any pointer load; sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cmd.wr && cmd.en && !ptr_ok_q)
            err_q <= 1'b1;
    end
endmodule

// File: rtl/irq_remap_ctrl.sv
// Top of the interrupt remapping command controller. Joins the command
// decoder, the in-flight tag queue and the mode sequencer. Assumes req_done
// retires the oldest request and is raised only while requests are queued.
module irq_remap_ctrl #(
    parameter int AW    = 48,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_wr,
    input  logic [31:0]                cmd_wdata,
    output logic [31:0]                cmd_rdata,
    input  logic                       addr_wr,
    input  logic [AW-1:0]              addr_wdata,
    input  logic                       req_valid,
    output logic                       req_ready,
    output logic                       req_tag,
    input  logic                       req_done,
    output logic                       cpl_tag,
    output logic [$clog2(DEPTH+1)-1:0] inflight,
    output logic [AW-1:0]              active_ptr,
    output logic                       sts_remap_en,
    output logic                       sts_ptr_set,
    output logic                       proto_err
);
    irm_pkg::cmd_t cmd;
    logic [AW-1:0] addr_q;
    logic          pending;
    logic          q_full, q_empty;
    logic          accept;

    irm_cmd_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .cmd        (cmd),
        .addr_q     (addr_q),
        .cmd_rdata  (cmd_rdata)
    );

    irm_inflight_q #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_tag (sts_remap_en),
        .pop      (req_done),
        .count    (inflight),
        .head_tag (cpl_tag),
        .full     (q_full),
        .empty    (q_empty)
    );

    irm_mode_ctrl #(.AW(AW)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .addr_q   (addr_q),
        .q_empty  (q_empty),
        .mode_q   (sts_remap_en),
        .pending  (pending),
        .ptr_q    (active_ptr),
        .ptr_ok_q (sts_ptr_set),
        .err_q    (proto_err)
    );

    // Refuse requests while the queue is full or a mode change waits to drain.
    assign req_ready = !pending && !q_full;
    assign accept    = req_valid && req_ready;
    assign req_tag   = sts_remap_en;
endmodule

// File: rtl/irm_checker.sv
// Protocol checker for irq_remap_ctrl, bound into every instance of it.
module irm_checker #(
    parameter int AW    = 48,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_wr,
    input logic [31:0]                cmd_wdata,
    input logic [AW-1:0]              addr_q,
    input logic                       pending,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [$clog2(DEPTH+1)-1:0] inflight,
    input logic [AW-1:0]              active_ptr,
    input logic                       sts_remap_en,
    input logic                       sts_ptr_set,
    input logic                       proto_err
);
    localparam int CW = $clog2(DEPTH + 1);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(DEPTH));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == CW'(DEPTH)) |-> !req_ready);

    assert_refused_not_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && inflight == CW'(DEPTH)) |=> (inflight <= CW'(DEPTH)));

    assert_pending_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !req_ready);

    assert_mode_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight != '0) |=> $stable(sts_remap_en));

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[24]) |=> (sts_ptr_set && active_ptr == $past(addr_q)));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && cmd_wdata[24]) |=> $stable(active_ptr));

    assert_early_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[25] && !sts_ptr_set) |=> proto_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind irq_remap_ctrl irm_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (cmd_wdata),
    .addr_q       (addr_q),
    .pending      (pending),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .inflight     (inflight),
    .active_ptr   (active_ptr),
    .sts_remap_en (sts_remap_en),
    .sts_ptr_set  (sts_ptr_set),
    .proto_err    (proto_err)
);

// File: tb/tb_irq_remap_ctrl.sv
// Directed bench: inputs change on the falling edge, results are read on the
// next falling edge after the rising edge that produced them.
module tb_irq_remap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 48;
    localparam int DEPTH      = 4;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [31:0]   cmd_rdata;
    logic          addr_wr = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_tag;
    logic          req_done = 1'b0;
    logic          cpl_tag;
    logic [CW-1:0] inflight;
    logic [AW-1:0] active_ptr;
    logic          sts_remap_en, sts_ptr_set, proto_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_remap_ctrl #(.AW(AW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_done(req_done), .cpl_tag(cpl_tag), .inflight(inflight),
        .active_ptr(active_ptr), .sts_remap_en(sts_remap_en),
        .sts_ptr_set(sts_ptr_set), .proto_err(proto_err)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic wr_addr(input logic [AW-1:0] a);
        addr_wr = 1'b1; addr_wdata = a;
        tick(1);
        addr_wr = 1'b0; addr_wdata = '0;
    endtask

    task automatic wr_cmd(input logic en, input logic sp);
        cmd_wr = 1'b1;
        cmd_wdata = '0;
        cmd_wdata[25] = en;
        cmd_wdata[24] = sp;
        check("R4", "cmd_rdata during write", 64'(cmd_rdata), 64'h0);
        tick(1);
        cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic push(input logic exp_tag);
        check("R7", "req_ready before push", 64'(req_ready), 64'h1);
        check("R8", "req_tag at accept", 64'(req_tag), 64'(exp_tag));
        req_valid = 1'b1;
        tick(1);
        req_valid = 1'b0;
    endtask

    task automatic pop(input logic exp_tag);
        check("R8", "cpl_tag of oldest", 64'(cpl_tag), 64'(exp_tag));
        req_done = 1'b1;
        tick(1);
        req_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "active_ptr", 64'(active_ptr), 64'h0);
        check("R1", "sts_remap_en", 64'(sts_remap_en), 64'h0);
        check("R1", "sts_ptr_set", 64'(sts_ptr_set), 64'h0);
        check("R1", "inflight", 64'(inflight), 64'h0);
        check("R1", "proto_err", 64'(proto_err), 64'h0);
        check("R1", "req_ready", 64'(req_ready), 64'h1);
    endtask

    task automatic t_proto_err();
        wr_cmd(1'b1, 1'b0);
        check("R10", "flag after early enable", 64'(proto_err), 64'h1);
        tick(3);
        check("R10", "flag stays set", 64'(proto_err), 64'h1);
        do_reset();
        check("R10", "flag cleared by reset", 64'(proto_err), 64'h0);
        check("R1", "mode cleared by reset", 64'(sts_remap_en), 64'h0);
    endtask

    task automatic t_set_ptr();
        wr_addr(48'h0000_1234_5000);
        check("R2", "status before load", 64'(sts_ptr_set), 64'h0);
        wr_cmd(1'b0, 1'b1);
        check("R2", "active_ptr loaded", 64'(active_ptr), 64'h0000_1234_5000);
        check("R2", "sts_ptr_set", 64'(sts_ptr_set), 64'h1);
        check("R4", "cmd_rdata idle", 64'(cmd_rdata), 64'h0);
        wr_addr(48'h0000_9999_0000);
        wr_cmd(1'b0, 1'b0);
        tick(1);
        check("R3", "ptr kept after zero trigger", 64'(active_ptr), 64'h0000_1234_5000);
    endtask

    task automatic t_enable_empty();
        wr_cmd(1'b1, 1'b0);
        check("R10", "no flag once pointer set", 64'(proto_err), 64'h0);
        check("R5", "status one cycle after write", 64'(sts_remap_en), 64'h0);
        tick(1);
        check("R5", "status two cycles after write", 64'(sts_remap_en), 64'h1);
    endtask

    task automatic t_deferred_disable();
        push(1'b1);
        push(1'b1);
        check("R7", "inflight two", 64'(inflight), 64'h2);
        wr_cmd(1'b0, 1'b0);
        check("R6", "status held while busy", 64'(sts_remap_en), 64'h1);
        check("R6", "ready low while pending", 64'(req_ready), 64'h0);
        req_valid = 1'b1;
        tick(3);
        req_valid = 1'b0;
        check("R6", "no accept while pending", 64'(inflight), 64'h2);
        check("R6", "status still held", 64'(sts_remap_en), 64'h1);
        pop(1'b1);
        pop(1'b1);
        check("R6", "status at drain edge", 64'(sts_remap_en), 64'h1);
        tick(1);
        check("R6", "status one cycle after drain", 64'(sts_remap_en), 64'h0);
        check("R6", "ready restored", 64'(req_ready), 64'h1);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(1'b0);
        check("R7", "inflight full", 64'(inflight), 64'(DEPTH));
        check("R7", "ready low when full", 64'(req_ready), 64'h0);
        req_valid = 1'b1;
        tick(1);
        req_valid = 1'b0;
        check("R7", "refused request not counted", 64'(inflight), 64'(DEPTH));
        for (int i = 0; i < DEPTH; i++) pop(1'b0);
        check("R7", "drained", 64'(inflight), 64'h0);
    endtask

    task automatic t_same_cycle();
        check("R8", "tag before switch", 64'(req_tag), 64'h0);
        cmd_wr = 1'b1; cmd_wdata = 32'h0200_0000; req_valid = 1'b1;
        tick(1);
        cmd_wr = 1'b0; cmd_wdata = '0; req_valid = 1'b0;
        check("R8", "accepted with old mode", 64'(inflight), 64'h1);
        check("R6", "ready low after write", 64'(req_ready), 64'h0);
        pop(1'b0);
        tick(1);
        check("R5", "enabled after drain", 64'(sts_remap_en), 64'h1);
        push(1'b1);
        pop(1'b1);
    endtask

    task automatic t_ptr_live();
        push(1'b1);
        push(1'b1);
        wr_addr(48'h0000_00AB_C000);
        wr_cmd(1'b1, 1'b1);
        check("R9", "pointer updated live", 64'(active_ptr), 64'h0000_00AB_C000);
        check("R9", "mode unchanged", 64'(sts_remap_en), 64'h1);
        check("R9", "ready unchanged", 64'(req_ready), 64'h1);
        check("R9", "queue untouched", 64'(inflight), 64'h2);
        pop(1'b1);
        pop(1'b1);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_proto_err();
        t_set_ptr();
        t_enable_empty();
        t_deferred_disable();
        t_full();
        t_same_cycle();
        t_ptr_live();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule